// File: doc/BRIEF.md
# Virtualization Intercept Decision Unit

This block decides, for each event raised while a guest runs, whether that event must leave the guest and return control to the hypervisor. It keeps six intercept control words: one 64-bit general vector, separate 16-bit masks for control-register reads and writes, separate 16-bit masks for debug-register reads and writes, and a 32-bit exception mask. All six words are written together in a single strobe cycle when the hypervisor enters a guest. On the way back to the host, a clear strobe empties the general vector and the exception mask.

An event arrives as an exit-code value with a guest-mode flag and a flag that marks a model-specific-register access. The unit works out which code range the value falls into, subtracts that range's base, and tests the resulting bit of the mask that belongs to the range. One cycle later it reports a registered result, which is either a direct exit or a request for a permission-map lookup, and repeats the exit code beside it. Fetching the words from memory, saving state on exit and walking the permission maps are done by neighbouring logic.

Top module: `icpt_decide`

## Requirements
- R1: After reset all six control words are zero, so no event reports a hit, and `res_valid`, `res_exit` and `res_perm` are low while reset is held.
- R2: Codes 0x000 to 0x008 test bit (code − 0x000) of the control-register read mask.
- R3: Codes 0x010 to 0x018 test bit (code − 0x010) of the control-register write mask.
- R4: Codes 0x020 to 0x027 test bit (code − 0x020) of the debug-register read mask, and codes 0x030 to 0x037 test bit (code − 0x030) of the debug-register write mask.
- R5: Codes 0x040 to 0x05F test bit (code − 0x040) of the 32-bit exception mask.
- R6: Codes 0x060 to 0x09F test bit (code − 0x060) of the 64-bit general vector. Any other code, including the gaps between ranges (such as 0x009 to 0x00F) and values from 0x0A0 upward, never reports a hit.
- R7: An event with the guest-mode flag low reports neither exit nor lookup, whatever the masks hold.
- R8: A clear strobe sets the general vector and the exception mask to zero and leaves the four register masks unchanged. When load and clear come in the same cycle, the loaded values are kept.
- R9: A load strobe writes all six words in one cycle. An event in that same cycle is decided with the values held before the strobe.
- R10: On a hit, an event flagged as a model-specific-register access raises `res_perm` and not `res_exit`. Any other hit raises `res_exit` and not `res_perm`. A miss raises neither.
- R11: Each event presented with `ev_valid` produces `res_valid` for exactly one cycle, on the next clock, with `res_code` equal to the presented code. Cycles without an event keep `res_valid`, `res_exit` and `res_perm` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write all six control words this cycle |
| load_gen | input | 64 | General intercept vector to load |
| load_crr | input | 16 | Control-register read mask to load |
| load_crw | input | 16 | Control-register write mask to load |
| load_drr | input | 16 | Debug-register read mask to load |
| load_drw | input | 16 | Debug-register write mask to load |
| load_exc | input | 32 | Exception mask to load |
| clear_en | input | 1 | Return to host: zero the general vector and exception mask |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_code | input | 12 | Exit code of the event |
| ev_guest | input | 1 | Processor is in guest mode |
| ev_msr | input | 1 | Event is a model-specific-register access |
| res_valid | output | 1 | Result of the previous cycle's event |
| res_exit | output | 1 | Event must exit to the hypervisor |
| res_perm | output | 1 | Event hit and needs a permission-map lookup |
| res_code | output | 12 | Exit code of the reported event |

## Verification
The assertions assume that all inputs are driven to known values from the first clock edge, with strobes and event flags low during reset. The same-cycle checks also depend on the fact that an event's result depends only on the words that were registered before its cycle. The clear-related property relies on `load_en` being sampled in the cycle that `clear_en` is. The bench changes inputs only on the falling edge and keeps both strobes low while reset is held. It sweeps every code from 0x000 to 0x0AF under more than one set of mask contents, and exercises the host-mode flag, the register-access flag and coincident strobes.

// File: rtl/icpt_pkg.sv
package icpt_pkg;
    // Code ranges; the ranged classes keep numeric order 0..4 for the decoder loop.
    typedef enum logic [2:0] {
        CLS_CRR  = 3'd0,
        CLS_CRW  = 3'd1,
        CLS_DRR  = 3'd2,
        CLS_DRW  = 3'd3,
        CLS_EXC  = 3'd4,
        CLS_GEN  = 3'd5,
        CLS_NONE = 3'd6
    } icpt_class_e;

    localparam int unsigned DEF_CODE_W   = 12;
    localparam int unsigned DEF_GEN_W    = 64;
    localparam int unsigned DEF_CR_W     = 16;
    localparam int unsigned DEF_DR_W     = 16;
    localparam int unsigned DEF_EXC_W    = 32;
    localparam int unsigned DEF_CR_SPAN  = 9;
    localparam int unsigned DEF_DR_SPAN  = 8;
    localparam int unsigned DEF_CRR_BASE = 'h000;
    localparam int unsigned DEF_CRW_BASE = 'h010;
    localparam int unsigned DEF_DRR_BASE = 'h020;
    localparam int unsigned DEF_DRW_BASE = 'h030;
    localparam int unsigned DEF_EXC_BASE = 'h040;
    localparam int unsigned DEF_GEN_BASE = 'h060;
endpackage

// File: rtl/icpt_mask_store.sv
module icpt_mask_store #(
    parameter int unsigned GEN_W = 64,
    parameter int unsigned CR_W  = 16,
    parameter int unsigned DR_W  = 16,
    parameter int unsigned EXC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [GEN_W-1:0] load_gen,
    input  logic [CR_W-1:0]  load_crr,
    input  logic [CR_W-1:0]  load_crw,
    input  logic [DR_W-1:0]  load_drr,
    input  logic [DR_W-1:0]  load_drw,
    input  logic [EXC_W-1:0] load_exc,
    input  logic             clear_en,
    output logic [GEN_W-1:0] gen_q_o,
    output logic [CR_W-1:0]  crr_q_o,
    output logic [CR_W-1:0]  crw_q_o,
    output logic [DR_W-1:0]  drr_q_o,
    output logic [DR_W-1:0]  drw_q_o,
    output logic [EXC_W-1:0] exc_q_o
);
    typedef struct packed {
        logic [GEN_W-1:0] gen;
        logic [CR_W-1:0]  crr;
        logic [CR_W-1:0]  crw;
        logic [DR_W-1:0]  drr;
        logic [DR_W-1:0]  drw;
        logic [EXC_W-1:0] exc;
    } words_t;

    words_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Exit to host drops the general and exception words only.
        if (clear_en) begin
            st_d.gen = '0;
            st_d.exc = '0;
        end
        // Entry load comes last so it wins over a coincident clear.
        if (load_en) begin
            st_d.gen = load_gen;
            st_d.crr = load_crr;
            st_d.crw = load_crw;
            st_d.drr = load_drr;
            st_d.drw = load_drw;
            st_d.exc = load_exc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gen_q_o = st_q.gen;
    assign crr_q_o = st_q.crr;
    assign crw_q_o = st_q.crw;
    assign drr_q_o = st_q.drr;
    assign drw_q_o = st_q.drw;
    assign exc_q_o = st_q.exc;
endmodule

// File: rtl/icpt_range_decode.sv
module icpt_range_decode
    import icpt_pkg::*;
#(
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned GEN_W    = 64,
    parameter int unsigned EXC_W    = 32,
    parameter int unsigned CR_SPAN  = 9,
    parameter int unsigned DR_SPAN  = 8,
    parameter int unsigned CRR_BASE = 'h000,
    parameter int unsigned CRW_BASE = 'h010,
    parameter int unsigned DRR_BASE = 'h020,
    parameter int unsigned DRW_BASE = 'h030,
    parameter int unsigned EXC_BASE = 'h040,
    parameter int unsigned GEN_BASE = 'h060,
    localparam int unsigned IDX_W   = $clog2(GEN_W)
) (
    input  logic [CODE_W-1:0] code_i,
    output icpt_class_e       cls_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int unsigned N_RANGED = 5;
    localparam int unsigned BASES [N_RANGED] = '{CRR_BASE, CRW_BASE, DRR_BASE, DRW_BASE, EXC_BASE};
    localparam int unsigned SPANS [N_RANGED] = '{CR_SPAN, CR_SPAN, DR_SPAN, DR_SPAN, EXC_W};

    int unsigned code_u;
    logic        found;

    always_comb begin
        code_u = 32'(code_i);
        found  = 1'b0;
        cls_o  = CLS_NONE;
        idx_o  = '0;
        for (int i = 0; i < int'(N_RANGED); i++) begin
            if (!found && code_u >= BASES[i] && code_u < BASES[i] + SPANS[i]) begin
                found = 1'b1;
                cls_o = icpt_class_e'(3'(i));
                idx_o = IDX_W'(code_u - BASES[i]);
            end
        end
        if (!found && code_u >= GEN_BASE && code_u < GEN_BASE + GEN_W) begin
            cls_o = CLS_GEN;
            idx_o = IDX_W'(code_u - GEN_BASE);
        end
    end
endmodule

// File: rtl/icpt_mask_select.sv
module icpt_mask_select
    import icpt_pkg::*;
#(
    parameter int unsigned GEN_W  = 64,
    parameter int unsigned CR_W   = 16,
    parameter int unsigned DR_W   = 16,
    parameter int unsigned EXC_W  = 32,
    localparam int unsigned IDX_W = $clog2(GEN_W)
) (
    input  icpt_class_e      cls_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [GEN_W-1:0] gen_i,
    input  logic [CR_W-1:0]  crr_i,
    input  logic [CR_W-1:0]  crw_i,
    input  logic [DR_W-1:0]  drr_i,
    input  logic [DR_W-1:0]  drw_i,
    input  logic [EXC_W-1:0] exc_i,
    output logic             hit_o
);
    always_comb begin
        unique case (cls_i)
            CLS_CRR: hit_o = |(crr_i & (CR_W'(1)  << idx_i));
            CLS_CRW: hit_o = |(crw_i & (CR_W'(1)  << idx_i));
            CLS_DRR: hit_o = |(drr_i & (DR_W'(1)  << idx_i));
            CLS_DRW: hit_o = |(drw_i & (DR_W'(1)  << idx_i));
            CLS_EXC: hit_o = |(exc_i & (EXC_W'(1) << idx_i));
            CLS_GEN: hit_o = |(gen_i & (GEN_W'(1) << idx_i));
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/icpt_decide.sv
module icpt_decide
    import icpt_pkg::*;
#(
    parameter int unsigned CODE_W   = DEF_CODE_W,
    parameter int unsigned GEN_W    = DEF_GEN_W,
    parameter int unsigned CR_W     = DEF_CR_W,
    parameter int unsigned DR_W     = DEF_DR_W,
    parameter int unsigned EXC_W    = DEF_EXC_W,
    parameter int unsigned CR_SPAN  = DEF_CR_SPAN,
    parameter int unsigned DR_SPAN  = DEF_DR_SPAN,
    parameter int unsigned CRR_BASE = DEF_CRR_BASE,
    parameter int unsigned CRW_BASE = DEF_CRW_BASE,
    parameter int unsigned DRR_BASE = DEF_DRR_BASE,
    parameter int unsigned DRW_BASE = DEF_DRW_BASE,
    parameter int unsigned EXC_BASE = DEF_EXC_BASE,
    parameter int unsigned GEN_BASE = DEF_GEN_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [GEN_W-1:0]  load_gen,
    input  logic [CR_W-1:0]   load_crr,
    input  logic [CR_W-1:0]   load_crw,
    input  logic [DR_W-1:0]   load_drr,
    input  logic [DR_W-1:0]   load_drw,
    input  logic [EXC_W-1:0]  load_exc,
    input  logic              clear_en,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              ev_guest,
    input  logic              ev_msr,
    output logic              res_valid,
    output logic              res_exit,
    output logic              res_perm,
    output logic [CODE_W-1:0] res_code
);
    localparam int unsigned IDX_W = $clog2(GEN_W);

    logic [GEN_W-1:0] gen_q;
    logic [CR_W-1:0]  crr_q, crw_q;
    logic [DR_W-1:0]  drr_q, drw_q;
    logic [EXC_W-1:0] exc_q;
    icpt_class_e      cls;
    logic [IDX_W-1:0] idx;
    logic             sel_hit;

    icpt_mask_store #(.GEN_W(GEN_W), .CR_W(CR_W), .DR_W(DR_W), .EXC_W(EXC_W)) u_store (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .load_gen(load_gen), .load_crr(load_crr), .load_crw(load_crw),
        .load_drr(load_drr), .load_drw(load_drw), .load_exc(load_exc),
        .clear_en(clear_en),
        .gen_q_o(gen_q), .crr_q_o(crr_q), .crw_q_o(crw_q),
        .drr_q_o(drr_q), .drw_q_o(drw_q), .exc_q_o(exc_q)
    );

    icpt_range_decode #(
        .CODE_W(CODE_W), .GEN_W(GEN_W), .EXC_W(EXC_W),
        .CR_SPAN(CR_SPAN), .DR_SPAN(DR_SPAN),
        .CRR_BASE(CRR_BASE), .CRW_BASE(CRW_BASE), .DRR_BASE(DRR_BASE),
        .DRW_BASE(DRW_BASE), .EXC_BASE(EXC_BASE), .GEN_BASE(GEN_BASE)
    ) u_decode (
        .code_i(ev_code), .cls_o(cls), .idx_o(idx)
    );

    icpt_mask_select #(.GEN_W(GEN_W), .CR_W(CR_W), .DR_W(DR_W), .EXC_W(EXC_W)) u_select (
        .cls_i(cls), .idx_i(idx),
        .gen_i(gen_q), .crr_i(crr_q), .crw_i(crw_q),
        .drr_i(drr_q), .drw_i(drw_q), .exc_i(exc_q),
        .hit_o(sel_hit)
    );

    typedef struct packed {
        logic              valid;
        logic              exit_hit;
        logic              perm_hit;
        logic [CODE_W-1:0] code;
    } result_t;

    result_t res_d, res_q;
    logic    take;

    always_comb begin
        take           = ev_valid && ev_guest && sel_hit;
        res_d          = res_q;
        res_d.valid    = ev_valid;
        res_d.exit_hit = take && !ev_msr;
        res_d.perm_hit = take && ev_msr;
        if (ev_valid) res_d.code = ev_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_exit  = res_q.exit_hit;
    assign res_perm  = res_q.perm_hit;
    assign res_code  = res_q.code;
endmodule

// File: rtl/icpt_decide_chk.sv
module icpt_decide_chk #(
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned EXC_W    = 32,
    parameter int unsigned CR_SPAN  = 9,
    parameter int unsigned CRR_BASE = 'h000,
    parameter int unsigned CRW_BASE = 'h010,
    parameter int unsigned EXC_BASE = 'h040
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic              clear_en,
    input logic              ev_valid,
    input logic [CODE_W-1:0] ev_code,
    input logic              ev_guest,
    input logic              ev_msr,
    input logic              res_valid,
    input logic              res_exit,
    input logic              res_perm,
    input logic [CODE_W-1:0] res_code
);
    logic in_exc, in_gap;
    assign in_exc = 32'(ev_code) >= EXC_BASE && 32'(ev_code) < EXC_BASE + EXC_W;
    assign in_gap = 32'(ev_code) >= CRR_BASE + CR_SPAN && 32'(ev_code) < CRW_BASE;

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> !res_valid && !res_exit && !res_perm);

    assert_code_echo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> res_valid && res_code == $past(ev_code));

    assert_host_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_guest |=> !res_exit && !res_perm);

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_exit, res_perm}));

    assert_msr_no_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_msr |=> !res_exit);

    assert_plain_no_perm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_msr |=> !res_perm);

    assert_cleared_exc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && in_exc && $past(clear_en) && !$past(load_en) |=> !res_exit && !res_perm);

    assert_gap_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && in_gap |=> !res_exit && !res_perm);
endmodule

bind icpt_decide icpt_decide_chk #(
    .CODE_W(CODE_W), .EXC_W(EXC_W), .CR_SPAN(CR_SPAN),
    .CRR_BASE(CRR_BASE), .CRW_BASE(CRW_BASE), .EXC_BASE(EXC_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .clear_en(clear_en),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_guest(ev_guest), .ev_msr(ev_msr),
    .res_valid(res_valid), .res_exit(res_exit), .res_perm(res_perm), .res_code(res_code)
);

// File: tb/icpt_decide_test.sv
module icpt_decide_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en, clear_en, ev_valid, ev_guest, ev_msr;
    logic [63:0] load_gen;
    logic [15:0] load_crr, load_crw, load_drr, load_drw;
    logic [31:0] load_exc;
    logic [11:0] ev_code;
    logic        res_valid, res_exit, res_perm;
    logic [11:0] res_code;

    icpt_decide uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .load_gen(load_gen), .load_crr(load_crr), .load_crw(load_crw),
        .load_drr(load_drr), .load_drw(load_drw), .load_exc(load_exc),
        .clear_en(clear_en), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_guest(ev_guest), .ev_msr(ev_msr),
        .res_valid(res_valid), .res_exit(res_exit), .res_perm(res_perm), .res_code(res_code)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Reference state: the words as the spec says they stand after the last edge.
    bit [63:0] m_gen;
    bit [15:0] m_crr, m_crw, m_drr, m_drw;
    bit [31:0] m_exc;
    bit        x_valid, x_exit, x_perm;
    bit [11:0] x_code;
    string     x_tag;

    function automatic bit predict(int code);
        if (code <= 8)                   return m_crr[code];
        if (code >= 16 && code <= 24)    return m_crw[code - 16];
        if (code >= 32 && code <= 39)    return m_drr[code - 32];
        if (code >= 48 && code <= 55)    return m_drw[code - 48];
        if (code >= 64 && code <= 95)    return m_exc[code - 64];
        if (code >= 96 && code <= 159)   return m_gen[code - 96];
        return 1'b0;
    endfunction

    function automatic string tag_of(int code);
        if (code <= 8)                   return "R2";
        if (code >= 16 && code <= 24)    return "R3";
        if ((code >= 32 && code <= 39) || (code >= 48 && code <= 55)) return "R4";
        if (code >= 64 && code <= 95)    return "R5";
        return "R6";
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare();
        chk(x_tag, "res_valid", int'(res_valid), int'(x_valid));
        chk(x_tag, "res_exit",  int'(res_exit),  int'(x_exit));
        chk(x_tag, "res_perm",  int'(res_perm),  int'(x_perm));
        if (x_valid) chk(x_tag, "res_code", int'(res_code), int'(x_code));
    endtask

    task automatic step(string tag, bit v, int code, bit g, bit m, bit ld, bit cl);
        bit h;
        @(negedge clk);
        compare();
        ev_valid = v; ev_code = 12'(code); ev_guest = g; ev_msr = m;
        load_en = ld; clear_en = cl;
        h       = v && g && predict(code);
        x_valid = v;
        x_exit  = h && !m;
        x_perm  = h && m;
        x_code  = 12'(code);
        x_tag   = (tag == "") ? tag_of(code) : tag;
        if (cl) begin m_gen = '0; m_exc = '0; end
        if (ld) begin
            m_gen = load_gen; m_crr = load_crr; m_crw = load_crw;
            m_drr = load_drr; m_drw = load_drw; m_exc = load_exc;
        end
    endtask

    task automatic set_words(bit [63:0] g, bit [15:0] a, bit [15:0] b,
                             bit [15:0] c, bit [15:0] d, bit [31:0] e);
        load_gen = g; load_crr = a; load_crw = b; load_drr = c; load_drw = d; load_exc = e;
    endtask

    initial begin
        rst_n = 1'b0;
        load_en = 0; clear_en = 0; ev_valid = 0; ev_guest = 0; ev_msr = 0; ev_code = '0;
        set_words('0, '0, '0, '0, '0, '0);
        x_valid = 0; x_exit = 0; x_perm = 0; x_code = '0; x_tag = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "res_valid in reset", int'(res_valid), 0);
        chk("R1", "res_exit in reset",  int'(res_exit),  0);
        chk("R1", "res_perm in reset",  int'(res_perm),  0);
        rst_n = 1'b1;

        // R1: empty words after reset, nothing hits
        for (int c = 0; c < 176; c += 5) step("R1", 1, c, 1, 0, 0, 0);

        // R9: load strobe with an event in the same cycle uses the old (empty) words
        set_words(64'hA5A5_0F0F_3C3C_9669, 16'h0155, 16'h01AA, 16'h00F0, 16'h000F, 32'hDEAD_BEEF);
        step("R9", 1, 0, 1, 0, 1, 0);
        step("R9", 1, 0, 1, 0, 0, 0);

        // R2..R6: full sweep under the first word set, with idle gaps (R11)
        for (int c = 0; c < 176; c++) begin
            step("", 1, c, 1, 0, 0, 0);
            if (c % 17 == 0) step("R11", 0, 0, 0, 0, 0, 0);
        end

        // R7: host mode never intercepts
        for (int c = 0; c < 176; c += 3) step("R7", 1, c, 0, 0, 0, 0);
        // R10: register-access events ask for a lookup instead of exiting
        for (int c = 0; c < 176; c += 2) step("R10", 1, c, 1, 1, 0, 0);

        // R8: clear empties general and exception words, register masks stay
        step("R8", 0, 0, 0, 0, 0, 1);
        for (int c = 0; c < 176; c++) step("R8", 1, c, 1, 0, 0, 0);

        // R9: reload with a second set, event in the strobe cycle sees the cleared words
        set_words(~64'hA5A5_0F0F_3C3C_9669, 16'h00AB, 16'h0154, 16'h000F, 16'h00F0, 32'h1234_5678);
        step("R9", 1, 'h061, 1, 0, 1, 0);
        for (int c = 0; c < 176; c++) step("", 1, c, 1, c[0], 0, 0);

        // R8: load and clear together keep the loaded words
        set_words(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF);
        step("R8", 0, 0, 0, 0, 1, 1);
        for (int c = 0; c < 176; c += 4) step("R8", 1, c, 1, 0, 0, 0);

        // R11: flush last result and confirm the line goes quiet
        step("R11", 0, 0, 0, 0, 0, 0);
        step("R11", 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule